// File: doc/BRIEF.md
# Row-Multiplexed Dot-Matrix Scanner with Duty-Factor Dimming

This block drives a 7-row by 40-column LED dot array, which holds eight characters of 5x7 dots, by lighting one row at a time. While a row is lit, the column outputs present that row's bits for all eight characters. The bits come from a display RAM that the block addresses by row and reads with one cycle of latency, as a block RAM would. Every row owns a period of 64 scan steps. The brightness code sets how many of those steps, counted from the start of the period, keep the row strobe active. The codes follow a fixed non-linear scale, and the top code switches the array off completely.

Scan steps come from one of two tick enables: an internal oscillator tick or an external clock tick. A select input picks the source. A control bit can insert a divide-by-16 prescaler between the selected tick and the scan counter. The peak-current selection bit passes to a registered output. A blank input, driven by a software clear elsewhere in the chip, darkens the columns. Columns are also forced dark in the first step of each row period, so that the one-cycle RAM latency never shows the previous row's data on the new row.

Top module: `led_row_scanner`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it is released, `row_drive`, `col_drive` and `peak_out` are all zero. The scan position restarts at row 0, step 0, and the prescaler count restarts at 0.
- R2: When `use_int` is 1 only `int_tick` advances the scan and `ext_tick` is ignored. When `use_int` is 0 only `ext_tick` advances it and `int_tick` is ignored.
- R3: When `div16_en` is 1 the scan advances on every 16th selected tick, counted from reset: the 16th, 32nd, and so on. When it is 0 the scan advances on every selected tick.
- R4: Each row lasts 64 scan steps. Rows run 0, 1, ..., 6 and then return to 0. Row r lights only bit r of `row_drive`, so the row drive has at most one bit set.
- R5: `rd_row` carries the current row index. When columns are enabled, `col_drive` equals the `rd_data` returned for that row.
- R6: `bright_code` values 0 to 7 give 64, 34, 26, 17, 13, 8, 4 and 0 lit steps per row. The strobe is active in steps 0 to N-1 of each row period. Columns are never driven while no row is lit.
- R7: Code 7 holds the row and column drives at zero. Loading any other code brings the drives back on the next step.
- R8: In step 0 of every row period `col_drive` is zero, even while the row strobe is active.
- R9: While `blank` is 1, `col_drive` is zero and the row strobe keeps its normal timing.
- R10: `peak_out` shows the `peak_full` value from the previous clock (1 selects full peak current, 0 selects 12.5%).
- R11: Each output reflects the scan state and the inputs of the cycle before it, through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | Internal oscillator tick enable |
| ext_tick | input | 1 | External mux clock tick enable |
| use_int | input | 1 | Source select: 1 = internal, 0 = external |
| div16_en | input | 1 | 1 = divide selected ticks by 16 |
| bright_code | input | 3 | Brightness code, 0 brightest, 7 off |
| peak_full | input | 1 | Peak current select from the control word |
| blank | input | 1 | Software-clear blanking of the columns |
| rd_row | output | 3 | Display RAM row address |
| rd_data | input | 40 | Display RAM row data, one cycle after `rd_row` |
| row_drive | output | 7 | One-hot row strobe |
| col_drive | output | 40 | Column drive bits |
| peak_out | output | 1 | Registered peak current select |

## Verification
The bench runs the scan through every brightness code for at least one full frame with a tick every cycle, and checks every output in every cycle. This separates the lengths in the duty table, the dark step at the start of each row and the order of the rows. A RAM model returns a different pattern for each row, so data taken from the wrong row or with the wrong latency shows up as a mismatch. Separate runs use ticks on the unselected source, sparse ticks on the external source, and the divide-by-16 mode over a whole frame, which tells source selection apart from prescaling. Blanking and random toggling of the peak flag are applied while scanning at full brightness.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned BRIGHT_W = 3;

  // Lit fraction per brightness code, in parts per thousand
  function automatic int unsigned duty_permille(int unsigned code);
    case (code)
      0:       return 1000;
      1:       return 530;
      2:       return 400;
      3:       return 270;
      4:       return 200;
      5:       return 130;
      6:       return 66;
      default: return 0;
    endcase
  endfunction

  // Lit steps per row period, rounded to nearest
  function automatic int unsigned duty_slots(int unsigned code, int unsigned slots);
    return (slots * duty_permille(code) + 500) / 1000;
  endfunction
endpackage

// File: rtl/mux_tick_gen.sv
module mux_tick_gen #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic int_tick,
  input  logic ext_tick,
  input  logic use_int,
  input  logic div_en,
  output logic scan_tick
);
  localparam int unsigned DIV_W = $clog2(DIV);

  logic             mux_tick;
  logic [DIV_W-1:0] pcnt;

  assign mux_tick = use_int ? int_tick : ext_tick;

  always_ff @(posedge clk) begin
    if (rst)           pcnt <= '0;
    else if (mux_tick) pcnt <= (pcnt == DIV_W'(DIV - 1)) ? '0 : pcnt + 1'b1;
  end

  assign scan_tick = div_en ? (mux_tick && pcnt == DIV_W'(DIV - 1)) : mux_tick;
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int unsigned ROWS  = 7,
  parameter int unsigned SLOTS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  output logic [$clog2(ROWS)-1:0]  row_idx,
  output logic [$clog2(SLOTS)-1:0] slot_idx
);
  localparam int unsigned ROW_W  = $clog2(ROWS);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx  <= '0;
      slot_idx <= '0;
    end else if (step) begin
      if (slot_idx == SLOT_W'(SLOTS - 1)) begin
        slot_idx <= '0;
        row_idx  <= (row_idx == ROW_W'(ROWS - 1)) ? '0 : row_idx + 1'b1;
      end else begin
        slot_idx <= slot_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/duty_map.sv
module duty_map #(
  parameter int unsigned SLOTS = 64
) (
  input  logic [scan_pkg::BRIGHT_W-1:0]  code,
  output logic [$clog2(SLOTS+1)-1:0]     on_cnt
);
  localparam int unsigned ON_W   = $clog2(SLOTS + 1);
  localparam int unsigned NCODES = 1 << scan_pkg::BRIGHT_W;

  logic [ON_W-1:0] tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_tab
    assign tab[g] = ON_W'(scan_pkg::duty_slots(g, SLOTS));
  end

  assign on_cnt = tab[code];
endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner #(
  parameter int unsigned ROWS     = 7,
  parameter int unsigned COLS     = 40,
  parameter int unsigned SLOTS    = 64,
  parameter int unsigned PRESCALE = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           int_tick,
  input  logic                           ext_tick,
  input  logic                           use_int,
  input  logic                           div16_en,
  input  logic [scan_pkg::BRIGHT_W-1:0]  bright_code,
  input  logic                           peak_full,
  input  logic                           blank,
  output logic [$clog2(ROWS)-1:0]        rd_row,
  input  logic [COLS-1:0]                rd_data,
  output logic [ROWS-1:0]                row_drive,
  output logic [COLS-1:0]                col_drive,
  output logic                           peak_out
);
  localparam int unsigned ROW_W  = $clog2(ROWS);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned ON_W   = $clog2(SLOTS + 1);

  logic              scan_tick;
  logic [ROW_W-1:0]  row_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic [ON_W-1:0]   on_cnt;
  logic              strobe;
  logic              col_en;

  mux_tick_gen #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .int_tick(int_tick), .ext_tick(ext_tick),
    .use_int(use_int), .div_en(div16_en), .scan_tick(scan_tick)
  );

  scan_seq #(.ROWS(ROWS), .SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst(rst), .step(scan_tick),
    .row_idx(row_idx), .slot_idx(slot_idx)
  );

  duty_map #(.SLOTS(SLOTS)) u_duty (
    .code(bright_code), .on_cnt(on_cnt)
  );

  assign rd_row = row_idx;
  assign strobe = ON_W'(slot_idx) < on_cnt;
  // step 0 is dark: RAM data still belongs to the previous row
  assign col_en = strobe && (slot_idx != '0) && !blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_drive <= '0;
      col_drive <= '0;
      peak_out  <= 1'b0;
    end else begin
      row_drive <= strobe ? (ROWS'(1) << row_idx) : '0;
      col_drive <= col_en ? rd_data : '0;
      peak_out  <= peak_full;
    end
  end
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int unsigned ROWS = 7,
  parameter int unsigned COLS = 40
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    use_int,
  input logic                    int_tick,
  input logic [2:0]              bright_code,
  input logic                    blank,
  input logic                    peak_full,
  input logic [$clog2(ROWS)-1:0] rd_row,
  input logic [ROWS-1:0]         row_drive,
  input logic [COLS-1:0]         col_drive,
  input logic                    peak_out
);
  assert_row_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_drive));

  assert_cols_need_row_R6: assert property (@(posedge clk) disable iff (rst)
    (col_drive != '0) |-> (row_drive != '0));

  assert_off_code_dark_R7: assert property (@(posedge clk) disable iff (rst)
    (bright_code == 3'd7) |=> (row_drive == '0 && col_drive == '0));

  assert_blank_cols_R9: assert property (@(posedge clk) disable iff (rst)
    blank |=> (col_drive == '0));

  assert_peak_follow_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (peak_out == $past(peak_full)));

  assert_no_int_tick_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (use_int && !int_tick) |=> $stable(rd_row));
endmodule

bind led_row_scanner scan_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .use_int(use_int), .int_tick(int_tick),
  .bright_code(bright_code), .blank(blank), .peak_full(peak_full),
  .rd_row(rd_row), .row_drive(row_drive), .col_drive(col_drive),
  .peak_out(peak_out)
);

// File: tb/sim_led_row_scanner.sv
`timescale 1ns/1ps
module sim_led_row_scanner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_tick = 1'b0, ext_tick = 1'b0, use_int = 1'b1, div16_en = 1'b0;
  logic [2:0]  bright_code = 3'd0;
  logic        peak_full = 1'b0, blank = 1'b0;
  logic [2:0]  rd_row;
  logic [39:0] rd_data = '0;
  logic [6:0]  row_drive;
  logic [39:0] col_drive;
  logic        peak_out;

  int vectors = 0;
  int errors  = 0;
  int m_slot = 0, m_row = 0, m_pcnt = 0;
  int on_tab [8] = '{64, 34, 26, 17, 13, 8, 4, 0};

  always #5 clk = ~clk;

  led_row_scanner u0 (
    .clk(clk), .rst(rst), .int_tick(int_tick), .ext_tick(ext_tick),
    .use_int(use_int), .div16_en(div16_en), .bright_code(bright_code),
    .peak_full(peak_full), .blank(blank), .rd_row(rd_row), .rd_data(rd_data),
    .row_drive(row_drive), .col_drive(col_drive), .peak_out(peak_out)
  );

  function automatic logic [39:0] pat(int r);
    return {8{5'(r * 9 + 5)}} ^ (40'(r) * 40'h1F2E3D4C5B);
  endfunction

  // RAM model: one-cycle read latency
  always @(posedge clk) rd_data <= pat(int'(rd_row));

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (row %0d step %0d)", tag, act, exp, m_row, m_slot);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 row", 40'(row_drive), 40'd0);
    check("R1 col", col_drive, 40'd0);
    check("R1 peak", 40'(peak_out), 40'd0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_slot = 0; m_row = 0; m_pcnt = 0;
  endtask

  // one clock: expected outputs come from the model state of this cycle
  task automatic step(bit it, bit et, string trow, string tcol);
    logic [6:0]  er;
    logic [39:0] ec;
    logic        ep;
    bit          mt, tk;
    int          n;
    int_tick = it; ext_tick = et;
    n  = on_tab[bright_code];
    er = (m_slot < n) ? (7'd1 << m_row) : 7'd0;
    ec = ((m_slot < n) && m_slot != 0 && !blank) ? pat(m_row) : 40'd0;
    ep = peak_full;
    @(posedge clk); @(negedge clk);
    check(trow, 40'(row_drive), 40'(er));
    check(tcol, col_drive, ec);
    check("R10 peak", 40'(peak_out), 40'(ep));
    mt = use_int ? it : et;
    tk = 1'b0;
    if (mt) begin
      tk = div16_en ? (m_pcnt == 15) : 1'b1;
      m_pcnt = (m_pcnt + 1) % 16;
    end
    if (tk) begin
      if (m_slot == 63) begin
        m_slot = 0;
        m_row  = (m_row + 1) % 7;
      end else m_slot++;
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first cycle after reset shows row 0, step 0 with cols dark
    step(1, 0, "R1 R4 row", "R1 R8 col");
    // full brightness, more than a frame: R4, R5, R8, R11
    for (int i = 0; i < 500; i++) step(1, 0, "R4 R11 row", "R5 R8 col");
    // every brightness code over a full frame: R6, R7
    for (int c = 1; c < 8; c++) begin
      bright_code = 3'(c);
      for (int i = 0; i < 460; i++) step(1, 0, "R6 R7 row", "R6 R7 col");
    end
    // reactivation after the off code: R7
    bright_code = 3'd2;
    for (int i = 0; i < 140; i++) step(1, 0, "R7 row", "R7 col");
    // blanking and peak flag toggling: R9, R10
    bright_code = 3'd0;
    blank = 1'b1;
    for (int i = 0; i < 150; i++) begin
      peak_full = 1'($urandom_range(0, 1));
      step(1, 0, "R9 row", "R9 col");
    end
    blank = 1'b0;
    // unselected source ignored: R2
    for (int i = 0; i < 40; i++) step(0, 1, "R2 row", "R2 col");
    use_int = 1'b0;
    for (int i = 0; i < 40; i++) step(1, 0, "R2 row", "R2 col");
    for (int i = 0; i < 600; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 row", "R2 col");
    // divide-by-16 from reset, one full frame: R3
    use_int = 1'b1;
    do_reset();
    div16_en = 1'b1;
    for (int i = 0; i < 7300; i++) step(1, 0, "R3 row", "R3 col");
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), 0, "R3 row", "R3 col");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule